// File: doc/BRIEF.md
# Scan Chain Self-Test Sequencer with Signature Verdict

This block runs a self-test on one internal scan chain and reports a pass or fail verdict. A start pulse makes it shift a seed pattern into the chain from a dedicated serial line. It then pulses a capture and switches the chain input to a 16-bit pseudorandom generator. Each later pattern is a run of shift cycles followed by one capture cycle. While the chain shifts, the bits that leave it are folded into a 16-bit serial-input signature register.

After the last unload, the signature is compared with a golden value that was latched at start. The block then raises `done_o` together with exactly one of `pass_o` or `fail_o`. The chain length, the number of pseudorandom patterns and the golden value are sampled when the test starts. The logic under test sits outside the block. It is reached only through `scan_en_o`, `scan_in_o`, `capture_o` and `scan_out_i`.

Top module: `scan_selftest_ctrl`

## Requirements
- R1: While `rst_ni` is low, and right after it goes low mid-run, `scan_en_o`, `capture_o`, `done_o`, `pass_o` and `fail_o` are all 0.
- R2: `start_i` is accepted only in the idle or done state. On that edge `scan_len_i`, `pat_cnt_i` and `golden_i` are sampled. Later changes to them, and start pulses while a test runs, have no effect on timing or verdict.
- R3: The seed phase is the first L cycles after an accepted start. In it `scan_en_o` is 1 and `scan_in_o` equals `seed_bit_i`. `seed_bit_i` is ignored at all other times.
- R4: After the seed phase comes one capture cycle. Then come P+1 shift phases of L cycles, with a one-cycle capture between each adjacent pair (P+1 captures in total). `capture_o` is never high together with `scan_en_o` and never lasts two cycles. `done_o` rises exactly (P+2)(L+1) clock edges after the start edge.
- R5: The pattern generator is 16 bits wide and reloads 16'hACE1 on every accepted start. In each non-seed shift cycle `scan_in_o` is bit 0 of the register. The register then becomes `{r[0]^r[2]^r[3]^r[5], r[15:1]}`. It never advances outside shift cycles.
- R6: The signature register is cleared on every accepted start. In each non-seed shift cycle it updates as `s <= {1'b0, s[15:1]} ^ ((s[0]^scan_out_i) ? 16'hB400 : 16'h0)`. It is not updated during seed or capture cycles.
- R7: When the test ends, `pass_o` is 1 only if the final signature equals the latched golden value bit for bit. Otherwise `fail_o` is 1. Exactly one of them is high while `done_o` is high.
- R8: `pass_o` and `fail_o` stay 0 until `done_o` rises. `done_o`, `pass_o` and `fail_o` then hold their values until the next accepted start.
- R9: A `scan_len_i` of 0 acts as a chain length of 1.
- R10: Starting again from the done state clears the previous verdict and the signature. Identical runs repeated back to back give identical verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| scan_len_i | input | LEN_W | Chain length in cells (0 acts as 1) |
| pat_cnt_i | input | PAT_W | Number of pseudorandom patterns after the seed |
| golden_i | input | SIG_W | Known-good signature |
| seed_bit_i | input | 1 | Serial seed data line |
| scan_out_i | input | 1 | Bit leaving the scan chain |
| scan_en_o | output | 1 | Chain shift enable |
| scan_in_o | output | 1 | Bit entering the scan chain |
| capture_o | output | 1 | Capture pulse to the chain cells |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | Signature matched |
| fail_o | output | 1 | Signature mismatched |

## Verification
The sequencer is run with a behavioural chain model whose capture mixes neighbouring cells. Any error in the order of seed, capture and shift, or an off-by-one in the phase lengths, therefore changes the expected signature. Directed runs cover chain lengths 1 and 0, zero patterns, several patterns and a long chain. Random lengths, pattern counts and seeds cover the wider space. The golden value is either the signature computed in the bench or that signature with one bit flipped, which tells a real compare apart from a stuck verdict. Some runs change the sampled inputs and pulse start during the test, and keep toggling the seed line after the seed phase, to show these are ignored. Back-to-back runs show the state is cleared on restart.

// File: rtl/sbist_pkg.sv
package sbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_SHIFT,
    ST_CAPTURE,
    ST_COMPARE,
    ST_DONE
  } st_e;
endpackage

// File: rtl/sbist_lfsr.sv
module sbist_lfsr #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  TAPS = 16'h002D,
  parameter logic [W-1:0]  SEED = 16'hACE1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic step_i,
  output logic bit_o
);
  logic [W-1:0] r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     r_q <= SEED;
    else if (init_i) r_q <= SEED;
    else if (step_i) r_q <= {^(r_q & TAPS), r_q[W-1:1]};
  end

  assign bit_o = r_q[0];
endmodule

// File: rtl/sbist_sisr.sv
module sbist_sisr #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] POLY = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] s_q;
  logic         fb;

  assign fb = s_q[0] ^ din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= '0;
    else if (clr_i) s_q <= '0;
    else if (en_i)  s_q <= {1'b0, s_q[W-1:1]} ^ ({W{fb}} & POLY);
  end

  assign sig_o = s_q;
endmodule

// File: rtl/sbist_fsm.sv
module sbist_fsm
  import sbist_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned PAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] scan_len_i,
  input  logic [PAT_W-1:0] pat_cnt_i,
  output logic             accept_o,
  output st_e              st_o
);
  st_e              st_q;
  logic [LEN_W-1:0] bit_q, len_q;
  logic [PAT_W-1:0] pat_q, npat_q;
  logic             last_bit;

  assign accept_o = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign last_bit = (bit_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      pat_q  <= '0;
      len_q  <= LEN_W'(1);
      npat_q <= '0;
    end else if (accept_o) begin
      st_q   <= ST_SEED;
      bit_q  <= '0;
      pat_q  <= '0;
      len_q  <= (scan_len_i == '0) ? LEN_W'(1) : scan_len_i;
      npat_q <= pat_cnt_i;
    end else begin
      unique case (st_q)
        ST_SEED: begin
          if (last_bit) begin
            bit_q <= '0;
            st_q  <= ST_CAPTURE;
          end else begin
            bit_q <= bit_q + LEN_W'(1);
          end
        end
        ST_CAPTURE: st_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (last_bit) begin
            bit_q <= '0;
            if (pat_q == npat_q) begin
              st_q <= ST_COMPARE;
            end else begin
              pat_q <= pat_q + PAT_W'(1);
              st_q  <= ST_CAPTURE;
            end
          end else begin
            bit_q <= bit_q + LEN_W'(1);
          end
        end
        ST_COMPARE: st_q <= ST_DONE;
        ST_IDLE, ST_DONE: st_q <= st_q;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/scan_selftest_ctrl.sv
module scan_selftest_ctrl
  import sbist_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned PAT_W = 8,
  parameter int unsigned SIG_W = 16,
  parameter logic [SIG_W-1:0] SIG_POLY = 16'hB400,
  parameter logic [15:0] GEN_TAPS = 16'h002D,
  parameter logic [15:0] GEN_SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] scan_len_i,
  input  logic [PAT_W-1:0] pat_cnt_i,
  input  logic [SIG_W-1:0] golden_i,
  input  logic             seed_bit_i,
  input  logic             scan_out_i,
  output logic             scan_en_o,
  output logic             scan_in_o,
  output logic             capture_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o
);
  localparam int unsigned GEN_W = 16;

  st_e              st_w;
  logic             accept;
  logic             gen_bit;
  logic             shifting;
  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] golden_q;
  logic             pass_q, fail_q;

  sbist_fsm #(.LEN_W(LEN_W), .PAT_W(PAT_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .scan_len_i(scan_len_i),
    .pat_cnt_i (pat_cnt_i),
    .accept_o  (accept),
    .st_o      (st_w)
  );

  assign shifting = (st_w == ST_SHIFT);

  sbist_lfsr #(.W(GEN_W), .TAPS(GEN_TAPS), .SEED(GEN_SEED)) u_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(accept),
    .step_i(shifting),
    .bit_o (gen_bit)
  );

  sbist_sisr #(.W(SIG_W), .POLY(SIG_POLY)) u_sig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (shifting),
    .din_i (scan_out_i),
    .sig_o (sig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      golden_q <= '0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else if (accept) begin
      golden_q <= golden_i;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else if (st_w == ST_COMPARE) begin
      pass_q <= (sig == golden_q);
      fail_q <= (sig != golden_q);
    end
  end

  assign scan_en_o = (st_w == ST_SEED) || shifting;
  assign scan_in_o = (st_w == ST_SEED) ? seed_bit_i : gen_bit;
  assign capture_o = (st_w == ST_CAPTURE);
  assign done_o    = (st_w == ST_DONE);
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
endmodule

// File: rtl/sbist_chk.sv
module sbist_chk
  import sbist_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic scan_en_o,
  input logic capture_o,
  input logic done_o,
  input logic pass_o,
  input logic fail_o,
  input st_e  st_i
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !scan_en_o && !capture_o && !done_o && !pass_o && !fail_o);

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (st_i == ST_IDLE || st_i == ST_DONE) |=> st_i == ST_SEED);

  assert_busy_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && st_i == ST_SHIFT |=> st_i != ST_SEED);

  assert_cap_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_o && scan_en_o));

  assert_cap_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !capture_o);

  assert_compare_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_COMPARE |=> done_o);

  assert_one_verdict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({pass_o, fail_o}));

  assert_quiet_until_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !pass_o && !fail_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(pass_o) && $stable(fail_o));
endmodule

bind scan_selftest_ctrl sbist_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .scan_en_o(scan_en_o),
  .capture_o(capture_o),
  .done_o   (done_o),
  .pass_o   (pass_o),
  .fail_o   (fail_o),
  .st_i     (st_w)
);

// File: tb/sim_scan_selftest_ctrl.sv
`timescale 1ns/1ps
module sim_scan_selftest_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] scan_len_i = '0;
  logic [7:0] pat_cnt_i = '0;
  logic [15:0] golden_i = '0;
  logic seed_bit_i = 1'b0;
  logic scan_out_i;
  logic scan_en_o, scan_in_o, capture_o, done_o, pass_o, fail_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_selftest_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .scan_len_i(scan_len_i), .pat_cnt_i(pat_cnt_i), .golden_i(golden_i),
    .seed_bit_i(seed_bit_i), .scan_out_i(scan_out_i),
    .scan_en_o(scan_en_o), .scan_in_o(scan_in_o), .capture_o(capture_o),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  function automatic logic [MAXC-1:0] chain_shift(logic [MAXC-1:0] c, logic din, int len);
    logic [MAXC-1:0] n = c;
    for (int i = 0; i < len - 1; i++) n[i] = c[i+1];
    n[len-1] = din;
    return n;
  endfunction

  function automatic logic [MAXC-1:0] chain_capture(logic [MAXC-1:0] c, int len);
    logic [MAXC-1:0] n = c;
    for (int i = 0; i < len; i++)
      n[i] = c[i] ^ (c[(i+1)%len] & ~c[(i+2)%len]) ^ ((i % 3) == 0);
    return n;
  endfunction

  function automatic logic [15:0] gen_step(logic [15:0] r);
    return {r[0] ^ r[2] ^ r[3] ^ r[5], r[15:1]};
  endfunction

  function automatic logic [15:0] sig_step(logic [15:0] s, logic d);
    return {1'b0, s[15:1]} ^ ((s[0] ^ d) ? 16'hB400 : 16'h0000);
  endfunction

  function automatic logic [15:0] ref_sig(int len, int npat, logic [MAXC-1:0] seedv);
    logic [MAXC-1:0] c = '0;
    logic [15:0] g = 16'hACE1;
    logic [15:0] s = '0;
    for (int j = 0; j < len; j++) c = chain_shift(c, seedv[j], len);
    c = chain_capture(c, len);
    for (int p = 0; p <= npat; p++) begin
      for (int j = 0; j < len; j++) begin
        s = sig_step(s, c[0]);
        c = chain_shift(c, g[0], len);
        g = gen_step(g);
      end
      if (p < npat) c = chain_capture(c, len);
    end
    return s;
  endfunction

  // behavioural chain under test
  logic [MAXC-1:0] chain_q = '0;
  int cur_len = 1;
  assign scan_out_i = chain_q[0];
  always @(posedge clk) begin
    if (scan_en_o) chain_q <= chain_shift(chain_q, scan_in_o, cur_len);
    else if (capture_o) chain_q <= chain_capture(chain_q, cur_len);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input int len_in, input int npat, input logic [MAXC-1:0] seedv,
                     input bit good, input bit poke);
    int len = (len_in == 0) ? 1 : len_in;
    logic [15:0] exp_sig, gold, gm;
    int k = 0, caps = 0, shifts = 0, seed_bad = 0, gen_bad = 0, quiet_bad = 0;
    logic p_hold, f_hold;
    cur_len = len;
    exp_sig = ref_sig(len, npat, seedv);
    gold = good ? exp_sig : (exp_sig ^ (16'h1 << ($urandom % 16)));
    @(negedge clk);
    scan_len_i = 8'(len_in);
    pat_cnt_i  = 8'(npat);
    golden_i   = gold;
    start_i    = 1'b1;
    @(posedge clk);
    gm = 16'hACE1;
    while (k < 20000) begin
      @(negedge clk);
      k++;
      if (k == 1) start_i = 1'b0;
      if (k == 2) begin
        scan_len_i = 8'($urandom);
        pat_cnt_i  = 8'($urandom);
        golden_i   = 16'($urandom);
      end
      if (poke && k == 3) start_i = 1'b1;
      if (poke && k == 4) start_i = 1'b0;
      seed_bit_i = (k - 1 < len) ? seedv[k-1] : 1'($urandom);
      #1;
      if (done_o) break;
      if (pass_o || fail_o) quiet_bad++;
      if (capture_o) caps++;
      if (scan_en_o) begin
        shifts++;
        if (k - 1 < len) begin
          if (scan_in_o !== seed_bit_i) seed_bad++;
        end else begin
          if (scan_in_o !== gm[0]) gen_bad++;
          gm = gen_step(gm);
        end
      end
    end
    check(k - 1 == (npat + 2) * (len + 1), "R4 latency", k - 1, (npat + 2) * (len + 1));
    check(caps == npat + 1, "R4 captures", caps, npat + 1);
    check(shifts == (npat + 2) * len, "R4 shift cycles", shifts, (npat + 2) * len);
    check(seed_bad == 0, "R3 seed path", seed_bad, 0);
    check(gen_bad == 0, "R5 generator bits", gen_bad, 0);
    check(quiet_bad == 0, "R8 verdict before done", quiet_bad, 0);
    check(pass_o === (gold == exp_sig), "R7 R6 pass", pass_o, gold == exp_sig);
    check(fail_o === (gold != exp_sig), "R7 fail", fail_o, gold != exp_sig);
    p_hold = pass_o;
    f_hold = fail_o;
    repeat (3) @(negedge clk);
    #1;
    check(done_o && pass_o === p_hold && fail_o === f_hold, "R8 hold",
          {done_o, pass_o, fail_o}, {1'b1, p_hold, f_hold});
  endtask

  task automatic run_all();
    logic [MAXC-1:0] sv;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!scan_en_o && !capture_o && !done_o && !pass_o && !fail_o, "R1 reset",
          {scan_en_o, capture_o, done_o, pass_o, fail_o}, 0);
    rst_ni = 1'b1;
    sv = {8{32'hC3A5_1E77}};
    run(1, 0, sv, 1'b1, 1'b0);
    run(1, 3, sv, 1'b0, 1'b0);
    run(5, 0, sv, 1'b1, 1'b0);
    run(40, 2, {8{32'h0F0F_5A5A}}, 1'b1, 1'b0);
    run(12, 4, sv, 1'b1, 1'b1);   // R2 start pulse mid-run ignored
    run(0, 2, sv, 1'b1, 1'b0);    // R9 zero length
    run(0, 1, sv, 1'b0, 1'b0);    // R9
    // R10 repeat identical runs; a failing run then a passing one
    run(9, 3, sv, 1'b1, 1'b0);
    run(9, 3, sv, 1'b1, 1'b0);
    run(9, 3, sv, 1'b0, 1'b0);
    run(9, 3, sv, 1'b1, 1'b0);
    // R1 reset mid-run
    @(negedge clk);
    scan_len_i = 8'd20; pat_cnt_i = 8'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(!scan_en_o && !capture_o && !done_o && !pass_o && !fail_o, "R1 reset mid-run",
          {scan_en_o, capture_o, done_o, pass_o, fail_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [MAXC-1:0] rv;
      for (int w = 0; w < MAXC / 32; w++) rv[w*32 +: 32] = $urandom;
      run(1 + ($urandom % 40), $urandom % 6, rv, 1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R4 watchdog: got timeout expected done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule